// File: doc/BRIEF.md
# Microcoded Fuzzy Rule Inference Unit

This block runs the rule stage of a fuzzy controller. The rule base is a short microprogram. Each line describes one rule. It picks up to four antecedent activation levels (alphas) from a small register file that the fuzzifier fills. It joins them with programmable AND/OR connectives and yields a rule strength. It then folds that strength into the weight of one consequent membership function. Several rules that name the same consequent are merged by taking the maximum, so each weight ends up as the scale factor for its consequent set. This is the max-dot scheme the defuzzifier expects.

Software or a loader writes the microprogram and the alpha file while the unit is idle. A one-cycle `start` pulse clears every consequent weight. The unit then evaluates one rule per clock from line 0 until it reaches a line that carries the end flag, or the last line of the memory. A one-cycle `done` pulse then hands the weight table to the defuzzifier, which reads it through an asynchronous read port.

Top module: `fuzzy_rule_engine`

## Requirements
- R1: After reset `busy` and `done` are low and every consequent weight reads 0.
- R2: A `start` accepted while idle sets every consequent weight to 0 before the first rule of the run is applied, so no weight from an earlier run survives.
- R3: A rule line is laid out as sel0 [5:0], sel1 [11:6], sel2 [17:12], sel3 [23:18], enable mask [27:24] (bit k enables slot k), connectives [30:28], consequent index [37:31], end flag [38]. The enabled slots are combined from left to right, slot 0 first. Slot k (k ≥ 1) is joined to the running result by connective bit k-1, where 1 means OR (maximum) and 0 means AND (minimum).
- R4: Any subset of the four slots may be enabled. A single enabled slot gives its alpha unchanged. An empty mask gives strength 0 and leaves every weight as it was.
- R5: Each rule updates its consequent weight to the maximum of the old weight and the rule strength.
- R6: Rules are evaluated one per clock. For a program whose end flag sits on line N-1, `done` rises N cycles after the edge that accepts `start`, stays high for exactly one cycle, and is never high while `busy` is high.
- R7: A program that has no end flag stops after line 255, which gives a run of 256 cycles.
- R8: Program writes, alpha writes and further `start` pulses that arrive while `busy` is high are ignored.
- R9: While the unit is idle and `start` is low, the weight table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program line write strobe |
| prog_addr | input | 8 | Program line address |
| prog_data | input | 39 | Program line contents |
| alpha_we | input | 1 | Alpha register write strobe |
| alpha_addr | input | 6 | Alpha register index |
| alpha_data | input | 8 | Alpha value |
| start | input | 1 | Begin an inference run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| wt_addr | input | 7 | Consequent weight read index |
| wt_data | output | 8 | Consequent weight at `wt_addr` |

## Verification
A wrong connective decode, a wrong operand slot or a wrong mask bit shows up in the weight of one particular consequent. The effect appears as soon as the run finishes, so the bench gives each of 128 rules its own consequent and covers every mask against every connective pattern in one program. A stuck or wrongly stepping program counter changes the number of cycles between `start` and `done`, which shows within one run. Weights that leak between runs, or writes that slip through while busy, show up on the next readback that follows the run.

// File: rtl/fuzzy_rule_engine.sv
module fuzzy_rule_engine #(
  parameter int AW      = 8,
  parameter int N_ALPHA = 64,
  parameter int N_CONS  = 128,
  parameter int DEPTH   = 256
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    prog_we,
  input  logic [$clog2(DEPTH)-1:0]                prog_addr,
  input  logic [4*$clog2(N_ALPHA)+8+$clog2(N_CONS)-1:0] prog_data,
  input  logic                                    alpha_we,
  input  logic [$clog2(N_ALPHA)-1:0]              alpha_addr,
  input  logic [AW-1:0]                           alpha_data,
  input  logic                                    start,
  output logic                                    busy,
  output logic                                    done,
  input  logic [$clog2(N_CONS)-1:0]               wt_addr,
  output logic [AW-1:0]                           wt_data
);
  localparam int SW     = $clog2(N_ALPHA);
  localparam int CW     = $clog2(N_CONS);
  localparam int PW     = $clog2(DEPTH);
  localparam int RW     = 4*SW + 8 + CW;
  localparam int MASK_O = 4*SW;
  localparam int CONN_O = MASK_O + 4;
  localparam int CONS_O = CONN_O + 3;
  localparam int EOP_O  = CONS_O + CW;

  logic [RW-1:0] prog_mem  [DEPTH];
  logic [AW-1:0] alpha_mem [N_ALPHA];
  logic [AW-1:0] wt        [N_CONS];
  logic [PW-1:0] pc;
  logic          busy_q, done_q;

  logic [RW-1:0] line;
  logic [3:0]    mask;
  logic [3:0]    joins;
  logic [CW-1:0] cons;
  logic          eop;
  logic [AW-1:0] strength;

  assign line  = prog_mem[pc];
  assign mask  = line[MASK_O +: 4];
  assign joins = {line[CONN_O +: 3], 1'b0};
  assign cons  = line[CONS_O +: CW];
  assign eop   = line[EOP_O];

  always_comb begin
    logic [AW-1:0] v;
    logic          seen;
    strength = '0;
    seen     = 1'b0;
    for (int k = 0; k < 4; k++) begin
      v = alpha_mem[line[k*SW +: SW]];
      if (mask[k]) begin
        if (!seen)          strength = v;
        else if (joins[k])  strength = (v > strength) ? v : strength;
        else                strength = (v < strength) ? v : strength;
        seen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (prog_we && !busy_q) prog_mem[prog_addr] <= prog_data;
    if (alpha_we && !busy_q) alpha_mem[alpha_addr] <= alpha_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pc     <= '0;
      for (int i = 0; i < N_CONS; i++) wt[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          pc     <= '0;
          for (int i = 0; i < N_CONS; i++) wt[i] <= '0;
        end
      end else begin
        if (strength > wt[cons]) wt[cons] <= strength;
        if (eop || pc == PW'(DEPTH-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wt_data = wt[wt_addr];
endmodule

// File: rtl/fuzzy_rule_engine_chk.sv
module fuzzy_rule_engine_chk #(
  parameter int AW = 8,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] wt_addr,
  input logic [AW-1:0] wt_data
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_end_gives_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_cleared_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wt_data == '0);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!$stable(wt_addr) || $stable(wt_data)));
endmodule

bind fuzzy_rule_engine fuzzy_rule_engine_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wt_addr(wt_addr), .wt_data(wt_data)
);

// File: tb/fuzzy_rule_engine_tb_top.sv
`timescale 1ns/1ps
module fuzzy_rule_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [38:0] prog_data = '0;
  logic        alpha_we = 1'b0;
  logic [5:0]  alpha_addr = '0;
  logic [7:0]  alpha_data = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [6:0]  wt_addr = '0;
  logic [7:0]  wt_data;

  int total = 0;
  int bad = 0;
  int aref [64];
  int cyc;

  always #2.5 clk = ~clk;

  fuzzy_rule_engine dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .alpha_we(alpha_we), .alpha_addr(alpha_addr),
    .alpha_data(alpha_data), .start(start), .busy(busy), .done(done),
    .wt_addr(wt_addr), .wt_data(wt_data)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [38:0] mk(int s0, int s1, int s2, int s3,
                                     int m, int c, int k, int e);
    return {e[0], k[6:0], c[2:0], m[3:0], s3[5:0], s2[5:0], s1[5:0], s0[5:0]};
  endfunction

  function automatic int model(int s0, int s1, int s2, int s3, int m, int c);
    int sel [4];
    int r;
    bit seen;
    sel[0] = s0; sel[1] = s1; sel[2] = s2; sel[3] = s3;
    r = 0; seen = 0;
    for (int k = 0; k < 4; k++) begin
      if ((m >> k) & 1) begin
        if (!seen) r = aref[sel[k]];
        else if ((c >> (k-1)) & 1) r = (aref[sel[k]] > r) ? aref[sel[k]] : r;
        else r = (aref[sel[k]] < r) ? aref[sel[k]] : r;
        seen = 1;
      end
    end
    return r;
  endfunction

  task automatic wr_prog(int a, logic [38:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a[7:0]; prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wr_alpha(int a, int d);
    @(negedge clk);
    alpha_we = 1'b1; alpha_addr = a[5:0]; alpha_data = d[7:0];
    @(negedge clk);
    alpha_we = 1'b0;
  endtask

  task automatic read_wt(int a, output int v);
    wt_addr = a[6:0];
    #0.5;
    v = int'(wt_data);
  endtask

  task automatic run(bit disturb);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        prog_we = 1'b1; prog_addr = 8'd0; prog_data = mk(63, 0, 0, 0, 1, 0, 5, 1);
        alpha_we = 1'b1; alpha_addr = 6'd6; alpha_data = 8'd255;
        start = 1'b1;
      end
      if (disturb && cyc == 3) begin
        prog_we = 1'b0; alpha_we = 1'b0; start = 1'b0;
      end
    end
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, m, c, e;
    int s [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    for (int i = 0; i < 128; i++) begin
      read_wt(i, v);
      if (v != 0) check("R1 weight", v, 0);
    end
    check("R1 weights swept", 0, 0);

    for (int i = 0; i < 64; i++) begin
      aref[i] = (i * 37 + 11) % 256;
      if (i == 0) aref[i] = 0;
      if (i == 63) aref[i] = 255;
      wr_alpha(i, aref[i]);
    end

    // sweep: every mask against every connective pattern, one consequent each
    for (int k = 0; k < 128; k++)
      wr_prog(k, mk(k % 64, (k*5+3) % 64, (k*11+7) % 64, (k*13+1) % 64,
                    k % 16, k / 16, k, (k == 127) ? 1 : 0));
    run(0);
    check("R6 cycles for 128 rules", cyc, 128);
    for (int k = 0; k < 128; k++) begin
      s[0] = k % 64; s[1] = (k*5+3) % 64; s[2] = (k*11+7) % 64; s[3] = (k*13+1) % 64;
      m = k % 16; c = k / 16;
      e = model(s[0], s[1], s[2], s[3], m, c);
      read_wt(k, v);
      if ($countones(m[3:0]) > 1) check("R3 connective chain", v, e);
      else check("R4 subset mask", v, e);
    end

    // aggregation on one consequent, empty mask on another
    for (int i = 0; i < 10; i++)
      wr_prog(i, mk(i * 6, 0, 0, 0, 1, 0, 5, 0));
    wr_prog(10, mk(63, 63, 63, 63, 0, 7, 6, 1));
    run(0);
    check("R6 cycles for 11 rules", cyc, 11);
    e = 0;
    for (int i = 0; i < 10; i++) if (aref[i*6] > e) e = aref[i*6];
    read_wt(5, v); check("R5 max aggregation", v, e);
    read_wt(6, v); check("R4 empty mask strength 0", v, 0);
    read_wt(100, v); check("R2 cleared by new start", v, 0);

    // writes and start while busy are ignored
    run(1);
    check("R8 start while busy ignored", cyc, 11);
    read_wt(5, v); check("R8 run unaffected", v, e);
    run(0);
    read_wt(5, v); check("R8 program and alpha writes dropped", v, e);

    // no end flag: stops on last line
    for (int i = 0; i < 256; i++)
      wr_prog(i, (i == 255) ? mk(63, 0, 0, 0, 1, 0, 9, 0) : mk(0, 0, 0, 0, 0, 0, 9, 0));
    run(0);
    check("R7 run length without end flag", cyc, 256);
    read_wt(9, v); check("R7 last line applied", v, 255);

    repeat (20) @(negedge clk);
    read_wt(9, v); check("R9 weight held while idle", v, 255);
    check("R6 done low after pulse", int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule